// File: doc/BRIEF.md
# SDI Mode Clock Enable Generator

This block derives every mode-dependent clock enable that an SDI transmit path needs, all inside one system clock domain (nominally 148.5 MHz). A 2-bit mode select and a level select are classified into one of four operating kinds: HD, SD, 3G Level A and 3G Level B. In SD the transmit enable has to average 27 MHz, so pulses are spaced alternately 5 and 6 clocks apart (5.5 on average). In 3G Level B a data-ready strobe runs on every other clock. The video source consumes one 20-bit Y/C word per luma/chroma pair. Its enable therefore runs at half the SD pulse rate, gated by a Y/C select that flips on every SD pulse.

The enables are plain strobes and carry no data, so the block has no valid/ready handshake and nothing can push back on it. Consumers sample each enable on the clock edge where it is high. The SD enable is replicated on three identical output bits and the video enable on two, so that the load can be spread. The Y/C select and an output-path enable are also brought out for the neighbouring formatter. Reset is synchronous and active high.

Inputs are registered once. If a new mode or level changes the operating kind, all cadence state restarts. Cycle index 0 of the new kind is the clock cycle that follows the edge that sampled the new inputs.

Top module: `sdice_gen`

## Requirements
- R1: Mode code 00 selects HD, 01 selects SD and 10 selects 3G. Code 11 behaves exactly like HD. In HD, in code 11 and in 3G Level A (level input low), every enable output is held high.
- R2: In SD, sd_ce_o is high for single cycles only. The first pulse falls on cycle index 4 after a restart. The following gaps alternate 6, 5, 6, 5 cycles, so pulses fall where (index+1) mod 11 is 0 or 5.
- R3: In SD, yc_sel_o is 0 at cycle index 0, where 0 marks the next SD word as chroma. It inverts in the cycle after each SD pulse and holds otherwise.
- R4: In SD, vid_ce_o is high only on an SD pulse that coincides with yc_sel_o = 1. That is first at index 10 and then every 11 cycles.
- R5: In SD, out_ce_o equals the SD pulse and dr_ce_o is held high.
- R6: In 3G Level B (mode 10, level high), dr_ce_o is high at even cycle indices and low at odd ones, and sd_ce_o is held high.
- R7: In 3G Level B, vid_ce_o and out_ce_o follow dr_ce_o.
- R8: All bits of sd_ce_o are identical at all times, and so are all bits of vid_ce_o.
- R9: A change of operating kind restarts the SD cadence, the Y/C select and the Level B phase. Index 0 is the cycle after the edge that sampled the new inputs.
- R10: An input change that leaves the kind unchanged has no effect on any output. This covers the level input in SD or HD, and a switch between codes 00 and 11. In particular, the SD cadence continues without a break.
- R11: In the cycle after any edge with rst high, all enables are high and yc_sel_o is 0. The first edge after release that samples a non-HD mode starts index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode select: 00 HD, 01 SD, 10 3G, 11 treated as HD |
| level_b_i | input | 1 | In 3G, low selects Level A and high selects Level B |
| sd_ce_o | output | SD_COPIES (3) | SD transmit enable, identical copies |
| dr_ce_o | output | 1 | 3G Level B data-ready enable |
| vid_ce_o | output | VID_COPIES (2) | Video source enable, identical copies |
| yc_sel_o | output | 1 | Y/C mux select for the SD word stream (0 = chroma next) |
| out_ce_o | output | 1 | Enable for the output datapath |

## Verification
The bench walks through a sequence of mode and level settings. It covers long SD runs spanning several 11-cycle periods and Level B runs of even and odd length. It also covers HD, code 11 and Level A. Kind changes in the middle of a period separate a proper restart from a cadence that merely free-runs. Inputs that leave the kind unchanged, such as a level flip in SD or 00 changing to 11, separate a correct "ignored" from a spurious restart. Resets applied during SD and during Level B show that reset forces every enable high and clears the Y/C phase.

// File: rtl/sdice_pkg.sv
package sdice_pkg;

  typedef enum logic [1:0] {
    KIND_HD  = 2'd0,
    KIND_SD  = 2'd1,
    KIND_3GA = 2'd2,
    KIND_3GB = 2'd3
  } kind_t;

  localparam logic [1:0] SEL_SD = 2'b01;
  localparam logic [1:0] SEL_3G = 2'b10;

  // Codes 00 and 11 both fall to HD behaviour.
  function automatic kind_t classify(input logic [1:0] sel, input logic lvl);
    case (sel)
      SEL_SD:  return KIND_SD;
      SEL_3G:  return lvl ? KIND_3GB : KIND_3GA;
      default: return KIND_HD;
    endcase
  endfunction

endpackage

// File: rtl/sdice_mode_track.sv
module sdice_mode_track
  import sdice_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       level_b_i,
  output kind_t      kind_o,
  output logic       restart_o
);

  kind_t kind_d;

  always_comb kind_d = classify(mode_i, level_b_i);

  // A restart is requested only when the operating kind itself changes.
  assign restart_o = (kind_d != kind_o);

  always_ff @(posedge clk) begin
    if (rst) kind_o <= KIND_HD;
    else     kind_o <= kind_d;
  end

endmodule

// File: rtl/sdice_cadence.sv
module sdice_cadence #(
  parameter int SHORT_GAP = 5,
  parameter int LONG_GAP  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic run_i,
  output logic pulse_o,
  output logic yc_sel_o
);

  localparam int CNT_W = (LONG_GAP > 2) ? $clog2(LONG_GAP) : 1;
  localparam logic [CNT_W-1:0] END_S = CNT_W'(SHORT_GAP - 1);
  localparam logic [CNT_W-1:0] END_L = CNT_W'(LONG_GAP - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic             yc_q;

  assign pulse_o  = run_i && (cnt_q == (long_q ? END_L : END_S));
  assign yc_sel_o = yc_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      yc_q   <= 1'b0;
    end else if (run_i) begin
      if (pulse_o) begin
        cnt_q  <= '0;
        long_q <= ~long_q;
        yc_q   <= ~yc_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdice_half_rate.sv
module sdice_half_rate (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic run_i,
  output logic strobe_o
);

  logic ph_q;

  assign strobe_o = run_i && !ph_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) ph_q <= 1'b0;
    else if (run_i)       ph_q <= ~ph_q;
  end

endmodule

// File: rtl/sdice_fanout.sv
module sdice_fanout #(
  parameter int N = 2
) (
  input  logic         d_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_copy
    assign q_o[i] = d_i;
  end

endmodule

// File: rtl/sdice_gen.sv
module sdice_gen
  import sdice_pkg::*;
#(
  parameter int SHORT_GAP  = 5,
  parameter int LONG_GAP   = 6,
  parameter int SD_COPIES  = 3,
  parameter int VID_COPIES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mode_i,
  input  logic                  level_b_i,
  output logic [SD_COPIES-1:0]  sd_ce_o,
  output logic                  dr_ce_o,
  output logic [VID_COPIES-1:0] vid_ce_o,
  output logic                  yc_sel_o,
  output logic                  out_ce_o
);

  kind_t kind_q;
  logic  restart;
  logic  is_sd;
  logic  is_lb;
  logic  cad_pulse;
  logic  yc_sel;
  logic  lb_strobe;
  logic  sd_en;
  logic  vid_en;

  sdice_mode_track u_track (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .level_b_i (level_b_i),
    .kind_o    (kind_q),
    .restart_o (restart)
  );

  assign is_sd = (kind_q == KIND_SD);
  assign is_lb = (kind_q == KIND_3GB);

  sdice_cadence #(
    .SHORT_GAP (SHORT_GAP),
    .LONG_GAP  (LONG_GAP)
  ) u_cadence (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .run_i     (is_sd),
    .pulse_o   (cad_pulse),
    .yc_sel_o  (yc_sel)
  );

  sdice_half_rate u_half (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .run_i     (is_lb),
    .strobe_o  (lb_strobe)
  );

  always_comb begin
    sd_en    = 1'b1;
    dr_ce_o  = 1'b1;
    vid_en   = 1'b1;
    out_ce_o = 1'b1;
    if (is_sd) begin
      sd_en    = cad_pulse;
      vid_en   = cad_pulse && yc_sel;
      out_ce_o = cad_pulse;
    end else if (is_lb) begin
      dr_ce_o  = lb_strobe;
      vid_en   = lb_strobe;
      out_ce_o = lb_strobe;
    end
  end

  assign yc_sel_o = yc_sel;

  sdice_fanout #(.N(SD_COPIES)) u_sd_fan (
    .d_i (sd_en),
    .q_o (sd_ce_o)
  );

  sdice_fanout #(.N(VID_COPIES)) u_vid_fan (
    .d_i (vid_en),
    .q_o (vid_ce_o)
  );

endmodule

// File: rtl/sdice_gen_chk.sv
module sdice_gen_chk #(
  parameter int SD_N     = 3,
  parameter int VID_N    = 2,
  parameter int LONG_GAP = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic [SD_N-1:0]  sd_ce,
  input logic             dr_ce,
  input logic [VID_N-1:0] vid_ce,
  input logic             yc_sel,
  input logic             is_sd,
  input logic             is_lb,
  input logic             restart
);

  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !is_sd || sd_ce[0]) gap_q <= '0;
    else                                       gap_q <= gap_q + 8'd1;
  end

  p_copies_r8: assert property (@(posedge clk) disable iff (rst)
    (sd_ce == {SD_N{sd_ce[0]}}) && (vid_ce == {VID_N{vid_ce[0]}}));

  p_hd_high_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == 2'b00) |-> (sd_ce[0] && dr_ce && vid_ce[0]));

  p_sd_single_r2: assert property (@(posedge clk) disable iff (rst)
    (is_sd && sd_ce[0] && !restart) |=> !sd_ce[0]);

  p_sd_gap_r2: assert property (@(posedge clk) disable iff (rst)
    is_sd |-> (gap_q < 8'(LONG_GAP)));

  p_yc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (is_sd && !sd_ce[0] && !restart) |=> $stable(yc_sel));

  p_yc_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (is_sd && sd_ce[0] && !restart) |=> (yc_sel != $past(yc_sel)));

  p_vid_in_sd_r4: assert property (@(posedge clk) disable iff (rst)
    (is_sd && vid_ce[0]) |-> sd_ce[0]);

  p_lb_alt_r6: assert property (@(posedge clk) disable iff (rst)
    (is_lb && dr_ce && !restart) |=> !dr_ce);

  p_lb_vid_r7: assert property (@(posedge clk) disable iff (rst)
    is_lb |-> (vid_ce[0] == dr_ce));

  p_rst_r11: assert property (@(posedge clk)
    rst |=> (sd_ce[0] && dr_ce && vid_ce[0] && !yc_sel));

endmodule

bind sdice_gen sdice_gen_chk #(
  .SD_N     (SD_COPIES),
  .VID_N    (VID_COPIES),
  .LONG_GAP (LONG_GAP)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_i  (mode_i),
  .sd_ce   (sd_ce_o),
  .dr_ce   (dr_ce_o),
  .vid_ce  (vid_ce_o),
  .yc_sel  (yc_sel_o),
  .is_sd   (is_sd),
  .is_lb   (is_lb),
  .restart (restart)
);

// File: tb/sdice_gen_bench.sv
`timescale 1ns/1ps
module sdice_gen_bench;

  localparam int SD_N  = 3;
  localparam int VID_N = 2;
  localparam int NV    = 11;

  // Entry: {mode[10:9], level[8], cycles[7:0]}
  localparam logic [10:0] VECS [0:NV-1] = '{
    {2'b01, 1'b0, 8'd40},
    {2'b01, 1'b1, 8'd25},
    {2'b00, 1'b0, 8'd12},
    {2'b11, 1'b1, 8'd9},
    {2'b01, 1'b1, 8'd23},
    {2'b10, 1'b1, 8'd15},
    {2'b10, 1'b0, 8'd8},
    {2'b10, 1'b1, 8'd14},
    {2'b00, 1'b1, 8'd6},
    {2'b01, 1'b0, 8'd34},
    {2'b10, 1'b1, 8'd7}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = 2'b00;
  logic             level_b_i = 1'b0;
  logic [SD_N-1:0]  sd_ce_o;
  logic             dr_ce_o;
  logic [VID_N-1:0] vid_ce_o;
  logic             yc_sel_o;
  logic             out_ce_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sdice_gen u_sdice_gen (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .level_b_i (level_b_i),
    .sd_ce_o   (sd_ce_o),
    .dr_ce_o   (dr_ce_o),
    .vid_ce_o  (vid_ce_o),
    .yc_sel_o  (yc_sel_o),
    .out_ce_o  (out_ce_o)
  );

  // Kind codes: 0 HD, 1 SD, 2 3G-A, 3 3G-B
  function automatic int bkind(input logic [1:0] m, input logic l);
    if (m == 2'b01) return 1;
    if (m == 2'b10) return l ? 3 : 2;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input int kd, input int k, input string extra);
    int  ph;
    bit  e_sd, e_dr, e_vid, e_out, e_yc;
    int  npulse;
    ph    = (k + 1) % 11;
    e_sd  = 1; e_dr = 1; e_vid = 1; e_out = 1; e_yc = 0;
    if (kd == 1) begin
      e_sd   = (ph == 0) || (ph == 5);
      e_vid  = (ph == 0);
      e_out  = e_sd;
      npulse = (k / 11) * 2 + (((k % 11) >= 5) ? 1 : 0);
      e_yc   = npulse[0];
      check({"R3 yc_sel", extra}, int'(yc_sel_o), int'(e_yc));
    end else if (kd == 3) begin
      e_dr  = (k % 2) == 0;
      e_vid = e_dr;
      e_out = e_dr;
    end
    if (kd == 1) begin
      check({"R2 R8 sd_ce", extra}, int'(sd_ce_o), e_sd ? 7 : 0);
      check({"R4 R8 vid_ce", extra}, int'(vid_ce_o), e_vid ? 3 : 0);
      check({"R5 out_ce", extra}, int'(out_ce_o), int'(e_out));
      check({"R5 dr_ce", extra}, int'(dr_ce_o), 1);
    end else if (kd == 3) begin
      check({"R6 dr_ce", extra}, int'(dr_ce_o), int'(e_dr));
      check({"R6 sd_ce", extra}, int'(sd_ce_o), 7);
      check({"R7 vid_ce", extra}, int'(vid_ce_o), e_vid ? 3 : 0);
      check({"R7 out_ce", extra}, int'(out_ce_o), int'(e_out));
    end else begin
      check({"R1 all_high", extra}, int'({sd_ce_o, dr_ce_o, vid_ce_o, out_ce_o}), 127);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check({"R11 enables in reset ", tag}, int'({sd_ce_o, dr_ce_o, vid_ce_o, out_ce_o}), 127);
    check({"R11 yc_sel in reset ", tag}, int'(yc_sel_o), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    int k;
    int prev;
    repeat (3) @(negedge clk);
    check_reset_state("initial");

    // Table walk: a kind change restarts the index (R9), otherwise it continues (R10).
    rst  = 1'b0;
    prev = 0;
    k    = 0;
    for (int v = 0; v < NV; v++) begin
      int    kd;
      string extra;
      mode_i    = VECS[v][10:9];
      level_b_i = VECS[v][8];
      kd        = bkind(VECS[v][10:9], VECS[v][8]);
      if (kd != prev) begin
        k     = 0;
        extra = " R9 after-restart";
      end else begin
        extra = " R10 same-kind-change";
      end
      prev = kd;
      for (int c = 0; c < int'(VECS[v][7:0]); c++) begin
        @(negedge clk);
        check_cycle(kd, k, extra);
        k++;
      end
    end

    // Reset in the middle of SD (R11), then restart from index 0.
    mode_i = 2'b01; level_b_i = 1'b0;
    for (int c = 0; c < 7; c++) @(negedge clk);
    rst = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check_reset_state("during SD");
    end
    rst = 1'b0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      check_cycle(1, c, " R11 post-reset");
    end

    // Reset during Level B: data-ready forced high (R11).
    mode_i = 2'b10; level_b_i = 1'b1;
    for (int c = 0; c < 5; c++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("during LB");
    rst = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check_cycle(3, c, " R11 post-reset");
    end

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule